// File: doc/BRIEF.md
# Guarded Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a 32-bit audio signal processor. Each accepted operation multiplies two 32-bit two's-complement operands into a 64-bit signed product and sign-extends it to the 67-bit accumulator width. The product then either replaces the accumulator, is added to it, or is subtracted from it. Four guard bits above the 63-bit product field let a chain of accumulations pass through an intermediate overflow and come back into range without losing information.

From the new accumulator value the unit forms a 32-bit result word. In fractional (Q31) mode this is the upper product-width window. In integer mode it is the low word. The result is clamped to the positive or negative rail when the value does not fit. A 5-bit flag register is refreshed together with the result. Two 32-bit read windows onto the accumulator share bit 31. A synchronous clear empties the accumulator between independent filter passes.

Top module: `guarded_mac`

## Requirements
- R1: `op`=00 (multiply) loads the accumulator with the sign-extended signed product `opa*opb`.
- R2: `op`=01 (multiply-accumulate) adds the sign-extended product to the 67-bit accumulator, modulo 2^67. The guard bits 66..63 keep intermediate sums exact.
- R3: `op`=10 (multiply-subtract) subtracts the sign-extended product from the accumulator, modulo 2^67.
- R4: `op`=11 (refresh) leaves the accumulator unchanged and recomputes the result and flags from it in the selected mode.
- R5: With `frac_mode`=1 the result is accumulator bits 62..31. This holds unless bits 66..62 are not all equal, in which case the result is 0x7FFFFFFF for a positive accumulator and 0x80000000 for a negative one. With `frac_mode`=0 the result is bits 31..0, and the same clamp applies when bits 66..31 are not all equal.
- R6: `acc_hi` always shows accumulator bits 62..31 and `acc_lo` always shows bits 31..0, so both carry bit 31.
- R7: The flag bits are: bit 4 saturation (the clamp of R5 was applied), bit 3 zero (result equals 0) and bit 1 negative (result bit 31).
- R8: Flag bit 2 (margin) is set when any of accumulator bits 66..63 differs from bit 62.
- R9: Flag bit 0 (borrow) is the carry out of the 67-bit unsigned addition for `op`=01. For `op`=10 it is set when the old accumulator, read as unsigned, is below the extended product. It is 0 for `op`=00 and `op`=11.
- R10: A strobe on `in_valid` at a rising edge updates the accumulator, `result` and `flags` at that same edge. `out_valid` is high for exactly the following cycle.
- R11: While `in_valid` is low, changes on `op`, `frac_mode`, `opa` or `opb` leave the accumulator, `result` and `flags` unchanged.
- R12: `clr` zeroes the accumulator, `result` and `flags` at the next edge. It takes priority over `in_valid`, and `out_valid` is 0 after a clear.
- R13: Synchronous `rst` brings every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous accumulator clear |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 refresh |
| frac_mode | input | 1 | 1 fractional Q31 result, 0 integer result |
| opa | input | 32 | Signed operand A |
| opb | input | 32 | Signed operand B |
| result | output | 32 | Saturated result word |
| flags | output | 5 | {saturation, zero, margin, negative, borrow} |
| acc_hi | output | 32 | Accumulator bits 62..31 |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| out_valid | output | 1 | High the cycle after an accepted operation |

## Verification
The operand patterns include the following:
- Half times half in fractional mode and small mixed-sign integers. These separate the two result windows and show the sign handling.
- The most-negative value squared. This is the only product that reaches bit 62, so it drives saturation and the margin flag together.
- A chain of ten near-full-scale accumulations pushes the sum into the guard bits. Ten matching subtractions then bring it back to exactly zero, which proves the guard bits kept the sum exact.
- Plus and minus one around an empty accumulator. These expose the borrow and carry definitions.

The bench also wiggles idle operands without a strobe and fires a clear together with a strobe, which shows the hold and priority rules.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
  localparam int DATA_W  = 32;
  localparam int GUARD_W = 4;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSUB = 2'b10,
    OP_READ = 2'b11
  } gmac_op_e;

  // flag bit positions
  localparam int FL_SAT    = 4;
  localparam int FL_ZERO   = 3;
  localparam int FL_MARGIN = 2;
  localparam int FL_NEG    = 1;
  localparam int FL_BORROW = 0;
  localparam int FLAG_W    = 5;
endpackage

// File: rtl/gmac_mult.sv
module gmac_mult #(
  parameter int DW = 32,
  parameter int AW = 67
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [AW-1:0] prod_ext
);
  localparam int PRW = 2 * DW;
  localparam int EXT = AW - PRW;

  logic signed [PRW-1:0] a_w, b_w, prod;

  always_comb begin
    a_w  = $signed({{DW{a[DW-1]}}, a});
    b_w  = $signed({{DW{b[DW-1]}}, b});
    prod = a_w * b_w;
  end

  generate
    if (EXT > 0) begin : g_ext
      assign prod_ext = {{EXT{prod[PRW-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/gmac_accum.sv
module gmac_accum
  import gmac_pkg::*;
#(
  parameter int AW = 67
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          valid,
  input  logic [1:0]    op,
  input  logic [AW-1:0] prod_ext,
  output logic [AW-1:0] acc_q,
  output logic [AW-1:0] acc_nxt,
  output logic          borrow_nxt
);
  logic [AW:0] sum_w, dif_w;
  gmac_op_e    op_e;

  always_comb begin
    op_e  = gmac_op_e'(op);
    sum_w = {1'b0, acc_q} + {1'b0, prod_ext};
    dif_w = {1'b0, acc_q} - {1'b0, prod_ext};
    unique case (op_e)
      OP_MUL:  begin acc_nxt = prod_ext;     borrow_nxt = 1'b0;      end
      OP_MAC:  begin acc_nxt = sum_w[AW-1:0]; borrow_nxt = sum_w[AW]; end
      OP_MSUB: begin acc_nxt = dif_w[AW-1:0]; borrow_nxt = dif_w[AW]; end
      default: begin acc_nxt = acc_q;        borrow_nxt = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (valid)  acc_q <= acc_nxt;
  end

  // R1: multiply-only replaces the accumulator with the product
  assert_mul_load_R1: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr && op == OP_MUL) |=> (acc_q == $past(prod_ext)));

  // R11: no strobe, no change
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/gmac_sat.sv
module gmac_sat #(
  parameter int DW = 32,
  parameter int AW = 67
) (
  input  logic [AW-1:0] acc,
  input  logic          frac,
  output logic [DW-1:0] res,
  output logic          sat
);
  localparam int PW    = 2 * DW - 1;     // product field width
  localparam int FR_LO = DW - 1;         // fractional window low bit
  localparam int FR_TW = AW - PW + 1;    // bits that must agree, fractional
  localparam int IN_TW = AW - DW + 1;    // bits that must agree, integer

  logic [DW-1:0] pos_rail, neg_rail, raw;
  logic          fits;

  always_comb begin
    pos_rail = {1'b0, {(DW-1){1'b1}}};
    neg_rail = {1'b1, {(DW-1){1'b0}}};
    if (frac) begin
      raw  = acc[PW-1:FR_LO];
      fits = (acc[AW-1:PW-1] == {FR_TW{1'b0}}) || (acc[AW-1:PW-1] == {FR_TW{1'b1}});
    end else begin
      raw  = acc[DW-1:0];
      fits = (acc[AW-1:DW-1] == {IN_TW{1'b0}}) || (acc[AW-1:DW-1] == {IN_TW{1'b1}});
    end
    sat = !fits;
    res = fits ? raw : (acc[AW-1] ? neg_rail : pos_rail);
  end
endmodule

// File: rtl/gmac_flags.sv
module gmac_flags
  import gmac_pkg::*;
#(
  parameter int DW = 32,
  parameter int GW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              valid,
  input  logic [DW-1:0]     res_nxt,
  input  logic              sat_nxt,
  input  logic [GW:0]       top_bits,   // guard bits plus product sign bit
  input  logic              borrow_nxt,
  output logic [DW-1:0]     res_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic              out_valid_q
);
  logic [FLAG_W-1:0] flag_nxt;

  always_comb begin
    flag_nxt             = '0;
    flag_nxt[FL_SAT]     = sat_nxt;
    flag_nxt[FL_ZERO]    = (res_nxt == '0);
    flag_nxt[FL_MARGIN]  = (top_bits[GW:1] != {GW{top_bits[0]}});
    flag_nxt[FL_NEG]     = res_nxt[DW-1];
    flag_nxt[FL_BORROW]  = borrow_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      res_q       <= '0;
      flags_q     <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= valid;
      if (valid) begin
        res_q   <= res_nxt;
        flags_q <= flag_nxt;
      end
    end
  end

  // R5: a clamped result sits on one of the two rails
  assert_sat_rail_R5: assert property (@(posedge clk) disable iff (rst)
    flags_q[FL_SAT] |-> (res_q == {1'b0, {(DW-1){1'b1}}} || res_q == {1'b1, {(DW-1){1'b0}}}));

  // R7: registered zero and negative flags agree with the registered result
  assert_zero_neg_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |-> (flags_q[FL_ZERO] == (res_q == '0) && flags_q[FL_NEG] == res_q[DW-1]));
endmodule

// File: rtl/guarded_mac.sv
module guarded_mac
  import gmac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              frac_mode,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flags,
  output logic [DW-1:0]     acc_hi,
  output logic [DW-1:0]     acc_lo,
  output logic              out_valid
);
  localparam int PW = 2 * DW - 1;
  localparam int AW = PW + GW;

  logic [AW-1:0] prod_ext, acc_q, acc_nxt;
  logic          borrow_nxt, sat_nxt;
  logic [DW-1:0] res_nxt;

  gmac_mult #(.DW(DW), .AW(AW)) u_mult (
    .a(opa), .b(opb), .prod_ext(prod_ext)
  );

  gmac_accum #(.AW(AW)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .valid(in_valid), .op(op),
    .prod_ext(prod_ext), .acc_q(acc_q), .acc_nxt(acc_nxt), .borrow_nxt(borrow_nxt)
  );

  gmac_sat #(.DW(DW), .AW(AW)) u_sat (
    .acc(acc_nxt), .frac(frac_mode), .res(res_nxt), .sat(sat_nxt)
  );

  gmac_flags #(.DW(DW), .GW(GW)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .valid(in_valid),
    .res_nxt(res_nxt), .sat_nxt(sat_nxt), .top_bits(acc_nxt[AW-1:PW-1]),
    .borrow_nxt(borrow_nxt), .res_q(result), .flags_q(flags), .out_valid_q(out_valid)
  );

  assign acc_hi = acc_q[PW-1:DW-1];
  assign acc_lo = acc_q[DW-1:0];

  // R12: clear empties every visible register
  assert_clear_R12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_hi == '0 && acc_lo == '0 && result == '0 && flags == '0 && !out_valid));

  // R10: an accepted strobe is acknowledged one cycle later
  assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clr) |=> out_valid);
endmodule

// File: tb/guarded_mac_test.sv
module guarded_mac_test;
  logic        clk = 1'b0;
  logic        rst, clr, in_valid, frac_mode;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic [31:0] result, acc_hi, acc_lo;
  logic [4:0]  flags;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [66:0] m_acc;

  always #2.5 clk = ~clk;

  guarded_mac uut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .op(op),
    .frac_mode(frac_mode), .opa(opa), .opb(opb), .result(result),
    .flags(flags), .acc_hi(acc_hi), .acc_lo(acc_lo), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input string what, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [31:0] er, input logic [4:0] ef, input logic ev);
    chk(tag, "result", 67'(result), 67'(er));
    chk(tag, "flags", 67'(flags), 67'(ef));
    chk({tag, "/R6"}, "acc_hi", 67'(acc_hi), 67'(m_acc[62:31]));
    chk({tag, "/R6"}, "acc_lo", 67'(acc_lo), 67'(m_acc[31:0]));
    chk(tag, "out_valid", 67'(out_valid), 67'(ev));
  endtask

  // one operation; model follows R1-R3 arithmetic, R4, R5 clamp, R7-R9 flags
  task automatic do_op(input string tag, input logic [1:0] o, input logic fr,
                       input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p64;
    logic [66:0] p, nacc;
    logic [67:0] w;
    logic        brw, s, ok;
    logic [31:0] r;
    p64 = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    p   = {{3{p64[63]}}, p64};
    brw = 1'b0;
    case (o)
      2'b00: nacc = p;
      2'b01: begin w = {1'b0, m_acc} + {1'b0, p}; nacc = w[66:0]; brw = w[67]; end
      2'b10: begin brw = (m_acc < p); nacc = m_acc - p; end
      default: nacc = m_acc;
    endcase
    if (fr) ok = (nacc[66:62] == 5'h00) || (nacc[66:62] == 5'h1F);
    else    ok = (nacc[66:31] == '0) || (nacc[66:31] == '1);
    s = !ok;
    if (ok) r = fr ? nacc[62:31] : nacc[31:0];
    else    r = nacc[66] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    @(negedge clk);
    in_valid = 1'b1; op = o; frac_mode = fr; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    m_acc = nacc;
    check_all(tag, r, {s, (r == 32'h0), (nacc[66:63] != {4{nacc[62]}}), r[31], brw}, 1'b1);
  endtask

  task automatic do_clear(input logic with_strobe);
    @(negedge clk);
    clr = 1'b1; in_valid = with_strobe; op = 2'b00; opa = 32'h1234; opb = 32'h5678;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    m_acc = '0;
    check_all("R12", 32'h0, 5'h0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; op = 2'b00; frac_mode = 1'b0;
    opa = '0; opb = '0; m_acc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R13", 32'h0, 5'h0, 1'b0);
  endtask

  task automatic t_multiply();
    do_op("R1_frac_half", 2'b00, 1'b1, 32'h4000_0000, 32'h4000_0000);
    chk("R1", "half*half", 67'(result), 67'(32'h2000_0000));
    do_op("R1_int_mixed", 2'b00, 1'b0, 32'd7, 32'hFFFF_FFFD);
    chk("R1", "7*-3", 67'(result), 67'(32'hFFFF_FFEB));
    do_op("R7_zero", 2'b00, 1'b0, 32'h0, 32'hDEAD_BEEF);
  endtask

  task automatic t_saturate();
    do_op("R5_R8_minsq", 2'b00, 1'b1, 32'h8000_0000, 32'h8000_0000);
    chk("R5", "frac pos rail", 67'(result), 67'(32'h7FFF_FFFF));
    do_op("R5_int_neg", 2'b00, 1'b0, 32'h8000_0000, 32'h2);
    chk("R5", "int neg rail", 67'(result), 67'(32'h8000_0000));
    do_op("R5_int_pos", 2'b00, 1'b0, 32'h0001_0000, 32'h0001_0000);
  endtask

  task automatic t_guard_chain();
    do_clear(1'b0);
    for (int i = 0; i < 10; i++) do_op("R2_chain", 2'b01, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R8", "margin set", 67'(flags[2]), 67'(1'b1));
    do_op("R4_read_int", 2'b11, 1'b0, 32'h5, 32'h5);
    for (int i = 0; i < 10; i++) do_op("R3_unwind", 2'b10, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R2", "back to zero", 67'({acc_hi, acc_lo}), 67'(0));
  endtask

  task automatic t_borrow();
    do_clear(1'b0);
    do_op("R9_sub_borrow", 2'b10, 1'b0, 32'h1, 32'h1);
    chk("R9", "borrow", 67'(flags[0]), 67'(1'b1));
    do_op("R9_add_carry", 2'b01, 1'b0, 32'h1, 32'h1);
    chk("R9", "carry", 67'(flags[0]), 67'(1'b1));
    do_op("R4_read_frac", 2'b11, 1'b1, 32'h9, 32'h9);
  endtask

  task automatic t_idle_hold();
    logic [31:0] r0, h0, l0;
    logic [4:0]  f0;
    do_op("R10_setup", 2'b00, 1'b0, 32'h0000_1234, 32'hFFFF_0001);
    r0 = result; f0 = flags; h0 = acc_hi; l0 = acc_lo;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op = 2'(i); frac_mode = i[0]; opa = 32'h8000_0000 >> i; opb = 32'h7 + 32'(i);
    end
    @(negedge clk);
    chk("R10", "out_valid one cycle", 67'(out_valid), 67'(1'b0));
    chk("R11", "result held", 67'(result), 67'(r0));
    chk("R11", "flags held", 67'(flags), 67'(f0));
    chk("R11", "window held", 67'({h0, l0}), 67'({acc_hi, acc_lo}));
  endtask

  initial begin
    t_reset();
    t_multiply();
    t_saturate();
    t_guard_chain();
    t_borrow();
    t_idle_hold();
    do_op("R1_before_clr", 2'b00, 1'b0, 32'h55, 32'h3);
    do_clear(1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule